// File: doc/BRIEF.md
# Pointer-Indexed General Register File

This block holds sixteen 16-bit general-purpose registers and a 16-bit status word. An access mode chosen on every cycle decides which storage element the single read/write port touches. The port can name a register by a 4-bit field given with the access. It can also name a register through one of two 4-bit pointer fields kept in the upper half of the status word. The port can also reach those pointer fields themselves as data.

Four register modes and four pointer modes let one arithmetic flag pick between the two pointers. A loop over a register array can therefore switch its operand on the outcome of the previous operation, with no extra step to recompute the index. In a register mode the selected value can be presented as a memory address instead of as data. A separate port loads the flag byte, so the arithmetic unit can update the flags in the same cycle that the pointers are rewritten.

Top module: `ptr_regfile`

## Requirements
- R1: After reset every register and every bit of `status_out` read as zero.
- R2: Mode 0 reads register `dir_idx` combinationally. With `wr_en` high and `as_addr` low, `wr_data` is stored into that register at the next rising clock edge. No other register changes.
- R3: Status bits [11:8] form the low pointer and bits [15:12] the high pointer. Mode 1 accesses the register named by the low pointer and mode 2 the one named by the high pointer.
- R4: Modes 4, 5, 6 and 7 test the flag at status bit 0 (zero), bit 1 (negative), bit 2 (carry) and bit 3 (parity) respectively. The low pointer is used when the flag is 0 and the high pointer when it is 1.
- R5: With `as_addr` high in a register mode (0, 1, 2, 4–7), the selected value appears on `addr_out`, `addr_valid` is 1 and `rd_data` is 0. In every other case `addr_out` is 0 and `addr_valid` is 0. Any write requested while `as_addr` is high is ignored.
- R6: Modes 8 and 9 read the low and high pointer zero-extended to 16 bits, and a write stores `wr_data[3:0]` into that pointer only. Mode 10 reads status bits [15:8] zero-extended, and a write stores `wr_data[7:0]` there. None of these writes alters status bits [7:0].
- R7: Modes 12, 13, 14 and 15 access the low pointer as data when the flag at status bit 0, 1, 2 or 3 is 0, and the high pointer when it is 1. They read zero-extended and write `wr_data[3:0]`.
- R8: With `flag_we` high, `flag_wdata` replaces status bits [7:0] at the clock edge. This applies even when a pointer or register write happens in the same cycle, and the two writes do not disturb each other.
- R9: A read of the element being written in the same cycle returns its value from before the write.
- R10: Modes 3 and 11 read as zero, and writes in those modes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Access mode selector |
| dir_idx | input | 4 | Register number for mode 0 |
| as_addr | input | 1 | Present a register value as an address |
| wr_en | input | 1 | Write request for the selected element |
| wr_data | input | 16 | Write data |
| flag_we | input | 1 | Load the flag byte |
| flag_wdata | input | 8 | New flag byte |
| rd_data | output | 16 | Selected value as data |
| addr_out | output | 16 | Selected register value as an address |
| addr_valid | output | 1 | `addr_out` carries an address |
| status_out | output | 16 | Current status word |

## Verification
Two functions can meet in one cycle. The first pair is a pointer write (modes 8–10 or 12–15) together with a flag-byte load. The second is a flag-selected access together with a flag load that would change the flag it depends on. The bench drives these together in directed cycles and in a long random mix. A behavioural model uses the pre-edge flags to choose the pointer and then applies both writes to separate bit ranges. Every output is compared with the model on every cycle, before the clock edge.

// File: rtl/ptr_regfile_pkg.sv
package ptr_regfile_pkg;

    localparam int DATA_W = 16;
    localparam int NREGS  = 16;
    localparam int IDX_W  = $clog2(NREGS);
    localparam int FLAG_W = 8;

    localparam logic [3:0] MD_DIRECT = 4'd0;
    localparam logic [3:0] MD_PLO    = 4'd1;
    localparam logic [3:0] MD_PHI    = 4'd2;
    localparam logic [3:0] MD_NIB_LO = 4'd8;
    localparam logic [3:0] MD_NIB_HI = 4'd9;
    localparam logic [3:0] MD_PBYTE  = 4'd10;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_REG,
        TGT_PLO,
        TGT_PHI,
        TGT_PBYTE
    } target_e;

    typedef struct packed {
        target_e            kind;
        logic [IDX_W-1:0]   reg_idx;
    } sel_t;

    typedef struct packed {
        logic [IDX_W-1:0]   phi;
        logic [IDX_W-1:0]   plo;
        logic [FLAG_W-1:0]  flags;
    } status_t;

endpackage

// File: rtl/ptr_index_sel.sv
module ptr_index_sel
    import ptr_regfile_pkg::*;
(
    input  logic [3:0]        mode,
    input  logic [IDX_W-1:0]  dir_idx,
    input  status_t           status,
    output sel_t              sel
);

    logic cond;

    always_comb begin
        cond        = status.flags[mode[1:0]];
        sel.kind    = TGT_NONE;
        sel.reg_idx = '0;
        if (mode == MD_DIRECT) begin
            sel.kind    = TGT_REG;
            sel.reg_idx = dir_idx;
        end else if (mode == MD_PLO) begin
            sel.kind    = TGT_REG;
            sel.reg_idx = status.plo;
        end else if (mode == MD_PHI) begin
            sel.kind    = TGT_REG;
            sel.reg_idx = status.phi;
        end else if (mode[3:2] == 2'b01) begin
            sel.kind    = TGT_REG;
            sel.reg_idx = cond ? status.phi : status.plo;
        end else if (mode == MD_NIB_LO) begin
            sel.kind    = TGT_PLO;
        end else if (mode == MD_NIB_HI) begin
            sel.kind    = TGT_PHI;
        end else if (mode == MD_PBYTE) begin
            sel.kind    = TGT_PBYTE;
        end else if (mode[3:2] == 2'b11) begin
            sel.kind    = cond ? TGT_PHI : TGT_PLO;
        end
    end

    always_comb begin
        if (mode[3:2] == 2'b01 && !status.flags[mode[1:0]])
            assert_flag0_low_R4: assert (sel.reg_idx == status.plo);
    end

endmodule

// File: rtl/ptr_reg_array.sv
module ptr_reg_array
    import ptr_regfile_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NREGS,
    localparam int IW = $clog2(N)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    typedef struct packed {
        logic [N-1:0][W-1:0] r;
    } arr_t;

    arr_t         st_d, st_q;
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_dec
        assign hit[g] = we && (idx == IW'(g));

        assert_reg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[g] |=> $stable(st_q.r[g]));
        assert_reg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> st_q.r[g] == $past(wdata));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) st_d.r[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.r[idx];

endmodule

// File: rtl/ptr_status_reg.sv
module ptr_status_reg
    import ptr_regfile_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flag_we,
    input  logic [FLAG_W-1:0]  flag_wdata,
    input  logic               plo_we,
    input  logic [IDX_W-1:0]   plo_wdata,
    input  logic               phi_we,
    input  logic [IDX_W-1:0]   phi_wdata,
    output status_t            status
);

    status_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flag_we) st_d.flags = flag_wdata;
        if (plo_we)  st_d.plo   = plo_wdata;
        if (phi_we)  st_d.phi   = phi_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q;

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(st_q.flags));
    assert_flags_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> st_q.flags == $past(flag_wdata));
    assert_plo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !plo_we |=> $stable(st_q.plo));
    assert_phi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !phi_we |=> $stable(st_q.phi));

endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
    import ptr_regfile_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          mode,
    input  logic [IDX_W-1:0]    dir_idx,
    input  logic                as_addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                flag_we,
    input  logic [FLAG_W-1:0]   flag_wdata,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W-1:0]   addr_out,
    output logic                addr_valid,
    output logic [DATA_W-1:0]   status_out
);

    sel_t                sel;
    status_t             status;
    logic [DATA_W-1:0]   reg_rdata;
    logic [DATA_W-1:0]   value;
    logic                wr_ok;
    logic                reg_we, plo_we, phi_we;
    logic [IDX_W-1:0]    plo_wdata, phi_wdata;

    ptr_index_sel i_sel (
        .mode    (mode),
        .dir_idx (dir_idx),
        .status  (status),
        .sel     (sel)
    );

    ptr_reg_array #(.W(DATA_W), .N(NREGS)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .idx   (sel.reg_idx),
        .wdata (wr_data),
        .rdata (reg_rdata)
    );

    ptr_status_reg i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .plo_we     (plo_we),
        .plo_wdata  (plo_wdata),
        .phi_we     (phi_we),
        .phi_wdata  (phi_wdata),
        .status     (status)
    );

    always_comb begin
        wr_ok     = wr_en && !as_addr;
        reg_we    = wr_ok && (sel.kind == TGT_REG);
        plo_we    = wr_ok && (sel.kind == TGT_PLO || sel.kind == TGT_PBYTE);
        phi_we    = wr_ok && (sel.kind == TGT_PHI || sel.kind == TGT_PBYTE);
        plo_wdata = wr_data[IDX_W-1:0];
        phi_wdata = (sel.kind == TGT_PBYTE) ? wr_data[2*IDX_W-1:IDX_W]
                                            : wr_data[IDX_W-1:0];
        case (sel.kind)
            TGT_REG:   value = reg_rdata;
            TGT_PLO:   value = DATA_W'(status.plo);
            TGT_PHI:   value = DATA_W'(status.phi);
            TGT_PBYTE: value = DATA_W'({status.phi, status.plo});
            default:   value = '0;
        endcase
        if (as_addr && sel.kind == TGT_REG) begin
            addr_out   = value;
            addr_valid = 1'b1;
            rd_data    = '0;
        end else begin
            addr_out   = '0;
            addr_valid = 1'b0;
            rd_data    = value;
        end
    end

    assign status_out = status;

    assert_addr_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && as_addr && !flag_we) |=> $stable(status_out));
    assert_nib_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_NIB_LO || mode == MD_NIB_HI || mode[3:2] == 2'b11)
            |-> rd_data[DATA_W-1:IDX_W] == '0);
    assert_resv_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd3 || mode == 4'd11) |-> (rd_data == '0 && !addr_valid));
    assert_resv_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 4'd3 || mode == 4'd11) && !flag_we) |=> $stable(status_out));

endmodule

// File: tb/test_ptr_regfile.sv
`timescale 1ns/1ps
module test_ptr_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = '0;
    logic [3:0]  dir_idx = '0;
    logic        as_addr = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        flag_we = 1'b0;
    logic [7:0]  flag_wdata = '0;
    logic [15:0] rd_data, addr_out, status_out;
    logic        addr_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] m_reg [16];
    logic [15:0] m_st;

    always #2.5 clk = ~clk;

    ptr_regfile i_ptr_regfile (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dir_idx(dir_idx),
        .as_addr(as_addr), .wr_en(wr_en), .wr_data(wr_data),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .rd_data(rd_data),
        .addr_out(addr_out), .addr_valid(addr_valid), .status_out(status_out)
    );

    // -1: not a register access; otherwise register number
    function automatic int ref_reg(input logic [3:0] md, input logic [3:0] di);
        int r;
        r = -1;
        if (md == 0) r = di;
        else if (md == 1) r = m_st[11:8];
        else if (md == 2) r = m_st[15:12];
        else if (md >= 4 && md <= 7) r = m_st[md - 4] ? m_st[15:12] : m_st[11:8];
        return r;
    endfunction

    function automatic logic [15:0] ref_val(input logic [3:0] md, input logic [3:0] di);
        int r;
        r = ref_reg(md, di);
        if (r >= 0) return m_reg[r];
        if (md == 8) return {12'd0, m_st[11:8]};
        if (md == 9) return {12'd0, m_st[15:12]};
        if (md == 10) return {8'd0, m_st[15:8]};
        if (md >= 12) return {12'd0, (m_st[md - 12] ? m_st[15:12] : m_st[11:8])};
        return 16'd0;
    endfunction

    task automatic step(input logic [3:0] md, input logic [3:0] di, input logic aa,
                        input logic we, input logic [15:0] wd,
                        input logic fwe, input logic [7:0] fd, input string tag);
        logic [15:0] e_rd, e_ad, v;
        logic        e_av;
        int          r;
        @(negedge clk);
        mode = md; dir_idx = di; as_addr = aa; wr_en = we; wr_data = wd;
        flag_we = fwe; flag_wdata = fd;
        #1;
        r = ref_reg(md, di);
        v = ref_val(md, di);
        if (r >= 0 && aa) begin e_rd = 16'd0; e_ad = v; e_av = 1'b1; end
        else begin e_rd = v; e_ad = 16'd0; e_av = 1'b0; end
        checks++;
        if (rd_data !== e_rd || addr_out !== e_ad || addr_valid !== e_av || status_out !== m_st) begin
            fails++;
            $display("FAIL %s mode=%0d: rd=%h addr=%h av=%b st=%h expected rd=%h addr=%h av=%b st=%h",
                     tag, md, rd_data, addr_out, addr_valid, status_out, e_rd, e_ad, e_av, m_st);
        end
        @(posedge clk);
        if (we && !aa) begin
            if (r >= 0) m_reg[r] = wd;
            else if (md == 8) m_st[11:8] = wd[3:0];
            else if (md == 9) m_st[15:12] = wd[3:0];
            else if (md == 10) m_st[15:8] = wd[7:0];
            else if (md >= 12) begin
                if (m_st[md - 12]) m_st[15:12] = wd[3:0];
                else m_st[11:8] = wd[3:0];
            end
        end
        if (fwe) m_st[7:0] = fd;
    endtask

    function automatic string tag_of(input logic [3:0] md, input logic aa);
        if (aa) return "R5";
        case (md)
            4'd0: return "R2";
            4'd1, 4'd2: return "R3";
            4'd4, 4'd5, 4'd6, 4'd7: return "R4";
            4'd8, 4'd9, 4'd10: return "R6";
            4'd3, 4'd11: return "R10";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = 16'd0;
        m_st = 16'd0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of every register and the status word
        for (int i = 0; i < 16; i++) step(4'd0, 4'(i), 0, 0, 0, 0, 0, "R1");

        // R2: direct write then read
        step(4'd0, 4'd5, 0, 1, 16'h1234, 0, 0, "R2");
        step(4'd0, 4'd5, 0, 0, 0, 0, 0, "R2");
        // R9: read during write shows old value
        step(4'd0, 4'd5, 0, 1, 16'hBEEF, 0, 0, "R9");
        step(4'd0, 4'd5, 0, 0, 0, 0, 0, "R9");

        // R6: byte write sets low pointer 3, high pointer 7
        step(4'd10, 4'd0, 0, 1, 16'hFF73, 0, 0, "R6");
        step(4'd10, 4'd0, 0, 0, 0, 0, 0, "R6");
        // R3: pointer-indexed registers
        step(4'd1, 4'd0, 0, 1, 16'h0333, 0, 0, "R3");
        step(4'd2, 4'd0, 0, 1, 16'h0777, 0, 0, "R3");
        step(4'd0, 4'd3, 0, 0, 0, 0, 0, "R3");
        step(4'd0, 4'd7, 0, 0, 0, 0, 0, "R3");

        // R8: flags zero=1 carry=1
        step(4'd0, 4'd0, 0, 0, 0, 1, 8'h05, "R8");
        // R4: each flag-selected register mode
        step(4'd4, 4'd0, 0, 0, 0, 0, 0, "R4");
        step(4'd5, 4'd0, 0, 0, 0, 0, 0, "R4");
        step(4'd6, 4'd0, 0, 0, 0, 0, 0, "R4");
        step(4'd7, 4'd0, 0, 0, 0, 0, 0, "R4");

        // R5: address presentation, and write suppressed
        step(4'd4, 4'd0, 1, 1, 16'hDEAD, 0, 0, "R5");
        step(4'd4, 4'd0, 0, 0, 0, 0, 0, "R5");
        step(4'd9, 4'd0, 1, 1, 16'h000C, 0, 0, "R5");
        step(4'd9, 4'd0, 0, 0, 0, 0, 0, "R5");

        // R7: flag-selected pointer write (zero=1 -> high pointer)
        step(4'd12, 4'd0, 0, 1, 16'hFFFA, 0, 0, "R7");
        step(4'd13, 4'd0, 0, 0, 0, 0, 0, "R7");
        step(4'd10, 4'd0, 0, 0, 0, 0, 0, "R7");

        // R8: pointer write and flag load in the same cycle
        step(4'd8, 4'd0, 0, 1, 16'h0009, 1, 8'hA2, "R8");
        step(4'd10, 4'd0, 0, 0, 0, 0, 0, "R8");
        // flag-selected write while its own flag flips
        step(4'd13, 4'd0, 0, 1, 16'h0004, 1, 8'h00, "R8");
        step(4'd10, 4'd0, 0, 0, 0, 0, 0, "R8");

        // R10: reserved modes
        step(4'd3, 4'd0, 0, 1, 16'h5555, 0, 0, "R10");
        step(4'd11, 4'd0, 0, 1, 16'h5555, 0, 0, "R10");
        step(4'd10, 4'd0, 0, 0, 0, 0, 0, "R10");

        for (int n = 0; n < 600; n++) begin
            logic [3:0] md;
            logic       aa;
            md = 4'($urandom_range(0, 15));
            aa = ($urandom_range(0, 3) == 0);
            step(md, 4'($urandom_range(0, 15)), aa, 1'($urandom_range(0, 1)),
                 16'($urandom), ($urandom_range(0, 2) == 0), 8'($urandom), tag_of(md, aa));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule